// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block sits on the host side of an SPI link (mode 0, SCK idle low, data sampled on the rising edge) to a serial NOR flash. On a start strobe it erases either one sector or the whole array. For a sector erase it sends the sector-erase opcode and a 24-bit address. The address is packed according to the page-size mode in use: 264-byte pages or 256-byte binary pages. For a whole-array erase it sends a fixed four-byte opcode string. It then releases chip select on a byte boundary, which tells the flash to begin its self-timed erase.

After the command, the sequencer polls the flash status register until the device reports ready. It keeps chip select high for a programmable minimum number of clocks before every poll. When the device is ready, it pulses `done_o` for one clock and presents the erase-failure flag from the last status read. SCK is derived from the system clock by a divider: each half period lasts `CLK_DIV` clocks.

The controller runs the states IDLE → ERASE (command frame) → GAP (chip select high) → POLL (status frame). From POLL it goes back to GAP while the device is busy, or on to DONE when it is ready, and DONE returns to IDLE. The transitions are: start accepted (IDLE→ERASE), command frame sent (ERASE→GAP), gap elapsed (GAP→POLL), still busy (POLL→GAP), ready seen (POLL→DONE) and completion (DONE→IDLE).

Top module: `flash_erase_seq`

## Requirements
- R1: A sector erase sends exactly four bytes in one chip-select-low frame: 7Ch, then address bits 23..16, 15..8 and 7..0. Every byte is sent MSB first.
- R2: With `bin_page_i`=0 (264-byte pages), the address equals `page_i` shifted left by 9: bits 23..20 are zero, the page occupies bits 19..9, and bits 8..0 are zero.
- R3: With `bin_page_i`=1 (256-byte pages), the address equals `page_i` shifted left by 8: bits 23..19 are zero, the page occupies bits 18..8, and bits 7..0 are zero.
- R4: With `chip_mode_i`=1, the command frame is exactly C7h, 94h, 80h, 9Ah in that order, with no address bytes.
- R5: Chip select rises only after a whole number of bytes, with SCK low. SCK is low whenever chip select is high, and each SCK high phase lasts `CLK_DIV` clocks.
- R6: Chip select stays high for at least `GAP_MIN` clocks before each status poll frame.
- R7: Each poll frame is D7h followed by two read bytes. Bit 7 of the first read byte set to 1 means ready. Polling repeats until ready is seen, so a device that reports busy N times produces N+1 poll frames.
- R8: `err_o` takes bit 5 of the second read byte of the final poll. It changes only in the cycle where `done_o` is high, and it holds its value until the next completion.
- R9: `busy_o` rises the cycle after an accepted start. `done_o` is high for exactly one cycle, and `busy_o` is low in the cycle that follows it.
- R10: A start strobe seen while `busy_o` is high is ignored. The running command is unchanged, and no further frames follow completion.
- R11: Out of reset, `cs_n_o`=1, `sck_o`=0, `busy_o`=0, `done_o`=0 and `err_o`=0. Chip select is high whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| chip_mode_i | input | 1 | 1 = whole-array erase, 0 = sector erase |
| bin_page_i | input | 1 | 1 = 256-byte page addressing, 0 = 264-byte |
| page_i | input | PAGE_W | Page number inside the sector to erase |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Erase-failure flag from the final status read |
| sck_o | output | 1 | SPI clock, idle low |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
`busy_o` is due one clock after the start edge, so the bench drives start on a falling edge and samples busy on the next falling edge. `done_o` and `err_o` appear one clock after the final SCK falling edge of the ready poll, which also raises chip select. The bench waits for `done_o` on falling edges, checks that it is low one edge later, and reads `err_o` a few cycles on to confirm it holds. A flash model in the bench samples SCK and chip select on every falling clock edge. It records each frame, each chip-select-high gap and each SCK high phase, so byte contents, gap lengths and SCK timing are compared after the operation has ended, whatever their exact cycle.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_GAP,
        ST_POLL,
        ST_DONE
    } seq_state_t;

    localparam logic [7:0] OPC_SECTOR = 8'h7C;
    localparam logic [7:0] OPC_STATUS = 8'hD7;
    localparam logic [7:0] OPC_CHIP0  = 8'hC7;
    localparam logic [7:0] OPC_CHIP1  = 8'h94;
    localparam logic [7:0] OPC_CHIP2  = 8'h80;
    localparam logic [7:0] OPC_CHIP3  = 8'h9A;

    localparam int READY_BIT = 7;
    localparam int ERROR_BIT = 5;

endpackage

// File: rtl/fes_cmd_bytes.sv
module fes_cmd_bytes
    import fes_pkg::*;
#(
    parameter int PAGE_W = 11
) (
    input  logic              chip_mode,
    input  logic              bin_page,
    input  logic [PAGE_W-1:0] page,
    input  logic              poll_phase,
    input  logic [1:0]        idx,
    output logic [7:0]        tx_byte
);
    localparam int ADDR_W  = 24;
    localparam int SH_STD  = 9;
    localparam int SH_BIN  = 8;

    logic [ADDR_W-1:0] addr;

    always_comb begin
        if (bin_page)
            addr = ADDR_W'(page) << SH_BIN;
        else
            addr = ADDR_W'(page) << SH_STD;
    end

    always_comb begin
        if (poll_phase) begin
            tx_byte = (idx == 2'd0) ? OPC_STATUS : 8'h00;
        end else if (chip_mode) begin
            unique case (idx)
                2'd0: tx_byte = OPC_CHIP0;
                2'd1: tx_byte = OPC_CHIP1;
                2'd2: tx_byte = OPC_CHIP2;
                default: tx_byte = OPC_CHIP3;
            endcase
        end else begin
            unique case (idx)
                2'd0: tx_byte = OPC_SECTOR;
                2'd1: tx_byte = addr[23:16];
                2'd2: tx_byte = addr[15:8];
                default: tx_byte = addr[7:0];
            endcase
        end
    end
endmodule

// File: rtl/fes_spi_shifter.sv
module fes_spi_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       busy,
    output logic       done
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       sh_out;
    logic [7:0]       sh_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_idx <= '0;
            sh_out  <= '0;
            sh_in   <= '0;
            sck     <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    sh_out  <= tx;
                    div_cnt <= '0;
                    bit_idx <= '0;
                    sck     <= 1'b0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sck) begin
                    sck   <= 1'b1;
                    sh_in <= {sh_in[6:0], miso};
                end else begin
                    sck    <= 1'b0;
                    sh_out <= {sh_out[6:0], 1'b0};
                    if (bit_idx == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    assign mosi = sh_out[7];
    assign rx   = sh_in;
endmodule

// File: rtl/fes_gap_timer.sv
module fes_gap_timer #(
    parameter int GAP_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int GW = (GAP_MIN > 1) ? $clog2(GAP_MIN + 1) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_MIN - 1);

    logic [GW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != GAP_LAST)
            cnt <= cnt + GW'(1);
    end

    assign expired = run && (cnt == GAP_LAST);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int PAGE_W  = 11,
    parameter int CLK_DIV = 2,
    parameter int GAP_MIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              chip_mode_i,
    input  logic              bin_page_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              sck_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam logic [1:0] ERASE_LAST = 2'd3;
    localparam logic [1:0] POLL_LAST  = 2'd2;

    seq_state_t        state, nstate;
    logic [1:0]        idx;
    logic              chip_q, bin_q;
    logic [PAGE_W-1:0] page_q;
    logic              kick;
    logic              ready_q, err_q, done_q, cs_n_q;

    logic       sh_busy, sh_done;
    logic [7:0] tx_byte, rx_byte;
    logic       gap_expired;

    fes_cmd_bytes #(.PAGE_W(PAGE_W)) u_bytes (
        .chip_mode  (chip_q),
        .bin_page   (bin_q),
        .page       (page_q),
        .poll_phase (state == ST_POLL),
        .idx        (idx),
        .tx_byte    (tx_byte)
    );

    fes_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (kick),
        .tx    (tx_byte),
        .miso  (miso_i),
        .sck   (sck_o),
        .mosi  (mosi_o),
        .rx    (rx_byte),
        .busy  (sh_busy),
        .done  (sh_done)
    );

    fes_gap_timer #(.GAP_MIN(GAP_MIN)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_GAP),
        .expired (gap_expired)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start_i) nstate = ST_ERASE;
            ST_ERASE: if (sh_done && idx == ERASE_LAST) nstate = ST_GAP;
            ST_GAP:   if (gap_expired) nstate = ST_POLL;
            ST_POLL:  if (sh_done && idx == POLL_LAST)
                          nstate = ready_q ? ST_DONE : ST_GAP;
            ST_DONE:  nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            chip_q  <= 1'b0;
            bin_q   <= 1'b0;
            page_q  <= '0;
            kick    <= 1'b0;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            cs_n_q  <= 1'b1;
        end else begin
            kick   <= 1'b0;
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    cs_n_q <= 1'b1;
                    if (start_i) begin
                        chip_q <= chip_mode_i;
                        bin_q  <= bin_page_i;
                        page_q <= page_i;
                        idx    <= '0;
                        cs_n_q <= 1'b0;
                        kick   <= 1'b1;
                    end
                end
                ST_ERASE: begin
                    if (sh_done) begin
                        if (idx == ERASE_LAST) begin
                            cs_n_q <= 1'b1;
                        end else begin
                            idx  <= idx + 2'd1;
                            kick <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_expired) begin
                        cs_n_q  <= 1'b0;
                        idx     <= '0;
                        ready_q <= 1'b0;
                        kick    <= 1'b1;
                    end
                end
                ST_POLL: begin
                    if (sh_done) begin
                        if (idx == 2'd1)
                            ready_q <= rx_byte[READY_BIT];
                        if (idx == POLL_LAST) begin
                            cs_n_q <= 1'b1;
                            if (ready_q) begin
                                err_q  <= rx_byte[ERROR_BIT];
                                done_q <= 1'b1;
                            end
                        end else begin
                            idx  <= idx + 2'd1;
                            kick <= 1'b1;
                        end
                    end
                end
                ST_DONE: cs_n_q <= 1'b1;
                default: cs_n_q <= 1'b1;
            endcase
        end
    end

    assign busy_o = (state != ST_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;
    assign cs_n_o = cs_n_q;
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
    parameter int GAP_MIN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic sck_o,
    input logic cs_n_o
);
    localparam int HW = $clog2(GAP_MIN + 1) + 1;
    localparam logic [HW-1:0] HSAT = HW'(GAP_MIN);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= HSAT;
        else if (cs_n_o)
            hi_cnt <= (hi_cnt >= HSAT) ? HSAT : hi_cnt + HW'(1);
        else
            hi_cnt <= '0;
    end

    // R9: completion pulse is one cycle and ends the operation
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R11: idle keeps the flash deselected
    assert_idle_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !sck_o));

    // R5: SCK is parked low while chip select is high
    assert_sck_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);

    // R6: minimum chip-select-high time before every frame
    assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_cnt >= HSAT));

    // R8: error flag moves only with completion
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_o) |-> done_o);
endmodule

bind flash_erase_seq fes_checker #(.GAP_MIN(GAP_MIN)) u_fes_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .sck_o   (sck_o),
    .cs_n_o  (cs_n_o)
);

// File: tb/tb_flash_erase_seq.sv
`timescale 1ns/1ps
module tb_flash_erase_seq;
    localparam int PAGE_W  = 11;
    localparam int CLK_DIV = 2;
    localparam int GAP_MIN = 4;
    localparam int NF      = 128;
    localparam int NVEC    = 6;

    // vector: [17] chip, [16] 256-byte mode, [15:5] page, [4:1] busy polls, [0] error
    localparam logic [17:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b0, 11'h7FF, 4'd0, 1'b0},
        {1'b0, 1'b0, 11'h001, 4'd2, 1'b1},
        {1'b0, 1'b1, 11'h405, 4'd1, 1'b0},
        {1'b0, 1'b1, 11'h7FF, 4'd0, 1'b1},
        {1'b1, 1'b0, 11'h2AA, 4'd3, 1'b0},
        {1'b1, 1'b1, 11'h123, 4'd0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, chip_mode_i = 1'b0, bin_page_i = 1'b0;
    logic [PAGE_W-1:0] page_i = '0;
    logic busy_o, done_o, err_o, sck_o, cs_n_o, mosi_o;
    logic miso_r = 1'b0;

    int checks = 0, errors = 0, cycles = 0;

    always #4 clk = ~clk;

    flash_erase_seq #(.PAGE_W(PAGE_W), .CLK_DIV(CLK_DIV), .GAP_MIN(GAP_MIN)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chip_mode_i(chip_mode_i),
        .bin_page_i(bin_page_i), .page_i(page_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .sck_o(sck_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_r)
    );

    // ---------------- flash model ----------------
    int   busy_cfg = 0;
    logic err_cfg  = 1'b0;
    logic [7:0] fbyte [0:NF-1][0:3];
    int   flen [0:NF-1];
    int   fgap [0:NF-1];
    int   fcnt = 0, frame_bad = 0, sck_bad = 0;
    int   bits = 0, polls_seen = 0, hi_run = 0, sck_hi = 0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;
    logic [7:0]  cur = '0;
    logic [15:0] resp = '0;

    always @(negedge clk) begin
        cycles = cycles + 1;
        if (prev_cs && !cs_n_o) begin
            bits = 0; resp = '0; miso_r = 1'b0;
            if (fcnt < NF) begin flen[fcnt] = 0; fgap[fcnt] = hi_run; end
        end
        if (!prev_cs && cs_n_o) begin
            if (sck_o || (bits % 8) != 0) frame_bad = frame_bad + 1;
            if (fcnt < NF) fcnt = fcnt + 1;
            hi_run = 1;
        end else if (cs_n_o) begin
            hi_run = hi_run + 1;
        end
        if (!cs_n_o && !prev_sck && sck_o) begin
            cur  = {cur[6:0], mosi_o};
            bits = bits + 1;
            if ((bits % 8) == 0 && fcnt < NF) begin
                if (bits / 8 <= 4) fbyte[fcnt][bits/8-1] = cur;
                flen[fcnt] = bits / 8;
                if (bits == 8) begin
                    if (cur == 8'hD7) begin
                        polls_seen = polls_seen + 1;
                        resp = {(polls_seen > busy_cfg) ? 8'h80 : 8'h00,
                                err_cfg ? 8'h20 : 8'h00};
                    end else begin
                        polls_seen = 0;
                    end
                end
            end
        end
        if (sck_o) sck_hi = sck_hi + 1;
        if (prev_sck && !sck_o) begin
            if (sck_hi != CLK_DIV) sck_bad = sck_bad + 1;
            sck_hi = 0;
            if (!cs_n_o) begin miso_r = resp[15]; resp = {resp[14:0], 1'b0}; end
        end
        prev_sck = sck_o;
        prev_cs  = cs_n_o;
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic chip, input logic bin,
                                            input logic [10:0] pg, input int i);
        logic [23:0] a;
        a = bin ? {5'b0, pg, 8'b0} : {4'b0, pg, 9'b0};
        if (chip) begin
            case (i) 0: return 8'hC7; 1: return 8'h94; 2: return 8'h80; default: return 8'h9A; endcase
        end
        case (i) 0: return 8'h7C; 1: return a[23:16]; 2: return a[15:8]; default: return a[7:0]; endcase
    endfunction

    task automatic run_op(input logic chip, input logic bin, input logic [10:0] pg,
                          input int polls, input logic err, input logic inject);
        int base, wait_n, fb0, sb0;
        logic err_seen;
        base = fcnt; fb0 = frame_bad; sb0 = sck_bad;
        busy_cfg = polls; err_cfg = err;
        @(negedge clk);
        chip_mode_i = chip; bin_page_i = bin; page_i = pg; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R9 busy after start", busy_o, 1);
        if (inject) begin
            repeat (10) @(negedge clk);
            chip_mode_i = ~chip; bin_page_i = ~bin; page_i = ~pg; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_n = 0;
        while (done_o !== 1'b1 && wait_n < 20000) begin
            @(negedge clk); wait_n = wait_n + 1;
        end
        chk(done_o === 1'b1, "R9 done seen", done_o, 1);
        err_seen = err_o;
        chk(err_o === err, "R8 error flag", err_o, err);
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R9 single done", {done_o, busy_o}, 0);
        repeat (6) @(negedge clk);
        chk(err_o === err_seen, "R8 error held", err_o, err_seen);
        chk(fcnt - base == polls + 2, "R7 frame count", fcnt - base, polls + 2);
        chk(flen[base] == 4, "R1 R4 command length", flen[base], 4);
        for (int i = 0; i < 4; i++)
            chk(fbyte[base][i] == exp_byte(chip, bin, pg, i),
                chip ? "R4 chip byte" : (bin ? "R3 R1 sector byte" : "R2 R1 sector byte"),
                fbyte[base][i], exp_byte(chip, bin, pg, i));
        for (int f = base + 1; f < fcnt; f++) begin
            chk(flen[f] == 3 && fbyte[f][0] == 8'hD7, "R7 poll frame", fbyte[f][0], 8'hD7);
            chk(fgap[f] >= GAP_MIN, "R6 cs gap", fgap[f], GAP_MIN);
        end
        chk(frame_bad == fb0 && sck_bad == sb0, "R5 byte boundary and sck", frame_bad - fb0 + sck_bad - sb0, 0);
        if (inject) begin
            repeat (100) @(negedge clk);
            chk(fcnt - base == polls + 2 && busy_o === 1'b0, "R10 start ignored", fcnt - base, polls + 2);
        end
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o === 1'b1 && sck_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0,
            "R11 reset state", {cs_n_o, sck_o, busy_o, done_o, err_o}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o === 1'b1 && busy_o === 1'b0, "R11 idle after reset", {cs_n_o, busy_o}, 2'b10);

        for (int v = 0; v < NVEC; v++)
            run_op(VEC[v][17], VEC[v][16], VEC[v][15:5], int'(VEC[v][4:1]), VEC[v][0], 1'b0);

        // R10: second start mid-operation must not alter or repeat the command
        run_op(1'b0, 1'b0, 11'h155, 2, 1'b0, 1'b1);
        // R2 boundary: page zero gives an all-zero address
        run_op(1'b0, 1'b0, 11'h000, 0, 1'b0, 1'b0);
        // R3 boundary: top page bit lands on address bit 18
        run_op(1'b0, 1'b1, 11'h400, 1, 1'b1, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule